// File: doc/BRIEF.md
# Scaled-Index Address Arithmetic Unit

This unit forms a 32-bit offset from up to two general registers and a constant: an optional base register, plus an optional index register multiplied by 1, 2, 4 or 8, plus a signed 32-bit displacement. Subtraction is expressed as a negative displacement. The same hardware serves two uses. One is computing the offset of a memory operand. The other is pure register arithmetic, where only the computed value is wanted and no memory is touched.

The unit drives the select lines of two read ports on an external eight-entry register file and receives the read data in the same cycle. One cycle after an input strobe it presents the registered result, a structural-error flag and a protection-fault flag.

The structural-error flag reports illegal use of the stack-pointer register (register 4) in the index position. The protection-fault flag reports a real-mode memory access whose offset lies above 0xFFFF. An address-only request may produce any offset without a fault.

Top module: `sidx_agu`

## Requirements
- R1: `out_valid` is high exactly one cycle after `in_valid` was high, and low otherwise. While no request is in flight, `addr`, `err` and `fault` keep their last values. All outputs are 0 after reset.
- R2: With both registers enabled and different, `addr` = base + (index << scale) + disp, taken modulo 2^32. `scale` 0, 1, 2, 3 means multiply by 1, 2, 4, 8. A disp with bit 31 set acts as a subtraction.
- R3: A register whose enable is low contributes zero, whatever its select value is. With both enables low, `addr` equals `disp`.
- R4: Selecting the same register as base and as index with scale 1, 2 or 3 yields that register multiplied by 3, 5 or 9, plus disp.
- R5: An enabled index of register 4 with a nonzero `scale` sets `err`. It also forces `addr` to 0 and `fault` to 0.
- R6: An enabled index of register 4 together with an enabled base of register 4 sets `err`, even at scale 0. It forces `addr` and `fault` to 0.
- R7: Register 4 used once and unscaled, as base or as index, is legal: `err` is 0.
- R8: When `mem_access` and `real_mode` are both 1, `err` is 0 and `addr` exceeds 0xFFFF, `fault` is 1. Under the same conditions with `addr` at or below 0xFFFF, `fault` is 0.
- R9: When `mem_access` is 0 or `real_mode` is 0, `fault` is 0 for any offset.
- R10: `rd_sel_a` follows `base_sel` and `rd_sel_b` follows `idx_sel` in the same cycle. The read data are consumed in the cycle of the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| base_en | input | 1 | Base register used |
| base_sel | input | 3 | Base register number |
| idx_en | input | 1 | Index register used |
| idx_sel | input | 3 | Index register number |
| scale | input | 2 | Index shift amount (x1/x2/x4/x8) |
| disp | input | 32 | Two's-complement displacement |
| mem_access | input | 1 | A real memory access follows |
| real_mode | input | 1 | 64K offset limit in force |
| rd_sel_a | output | 3 | Register file read select, base port |
| rd_sel_b | output | 3 | Register file read select, index port |
| rd_data_a | input | 32 | Register file read data, base port |
| rd_data_b | input | 32 | Register file read data, index port |
| out_valid | output | 1 | Result strobe |
| addr | output | 32 | Computed offset |
| err | output | 1 | Illegal stack-pointer use |
| fault | output | 1 | Real-mode offset above 64K on a memory access |

## Verification
A corrupted result register shows as a wrong `addr` or wrong flags on the very strobe cycle that follows the request. It can also show as outputs that change on idle cycles, which breaks the hold rule one cycle after the strobe. A wrong rule decision appears at once as `err` set on a legal operand, or as `fault` set alongside `err`. A stale scale or enable path is exposed because the sweep crosses every register pair, every scale and every enable combination. In that sweep, each wrong term changes `addr` on the next strobe.

// File: rtl/agu_pkg.sv
package agu_pkg;
    localparam int AGU_DATA_W = 32;
    localparam int AGU_NREG   = 8;
    localparam int AGU_SEL_W  = $clog2(AGU_NREG);
    localparam int AGU_SCL_W  = 2;
    localparam logic [AGU_SEL_W-1:0] AGU_SP_SEL = 3'd4;

    typedef struct packed {
        logic                  valid;
        logic [AGU_DATA_W-1:0] addr;
        logic                  err;
        logic                  fault;
    } agu_out_t;
endpackage

// File: rtl/agu_scaler.sv
module agu_scaler #(
    parameter int W       = 32,
    parameter int SCALE_W = 2
) (
    input  logic               en,
    input  logic [W-1:0]       val,
    input  logic [SCALE_W-1:0] scale,
    output logic [W-1:0]       scaled
);
    always_comb begin
        scaled = en ? (val << scale) : '0;
    end
endmodule

// File: rtl/agu_sp_rule.sv
module agu_sp_rule #(
    parameter int SEL_W   = 3,
    parameter int SCALE_W = 2,
    parameter logic [SEL_W-1:0] SP_SEL = 3'd4
) (
    input  logic               base_en,
    input  logic [SEL_W-1:0]   base_sel,
    input  logic               idx_en,
    input  logic [SEL_W-1:0]   idx_sel,
    input  logic [SCALE_W-1:0] scale,
    output logic               bad
);
    logic base_is_sp;
    logic idx_is_sp;

    always_comb begin
        base_is_sp = base_en && (base_sel == SP_SEL);
        idx_is_sp  = idx_en && (idx_sel == SP_SEL);
        // stack pointer may not be scaled and may not appear twice
        bad = idx_is_sp && ((scale != '0) || base_is_sp);
    end
endmodule

// File: rtl/agu_sum3.sv
module agu_sum3 #(
    parameter int W = 32
) (
    input  logic         base_en,
    input  logic [W-1:0] base_val,
    input  logic [W-1:0] idx_term,
    input  logic [W-1:0] disp,
    output logic [W-1:0] sum
);
    logic [W-1:0] base_term;

    always_comb begin
        base_term = base_en ? base_val : '0;
        sum       = base_term + idx_term + disp;
    end
endmodule

// File: rtl/sidx_agu.sv
module sidx_agu
    import agu_pkg::*;
#(
    parameter int W       = AGU_DATA_W,
    parameter int SEL_W   = AGU_SEL_W,
    parameter int SCALE_W = AGU_SCL_W,
    parameter logic [W-1:0] OFFSET_MAX = 32'h0000_FFFF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               base_en,
    input  logic [SEL_W-1:0]   base_sel,
    input  logic               idx_en,
    input  logic [SEL_W-1:0]   idx_sel,
    input  logic [SCALE_W-1:0] scale,
    input  logic [W-1:0]       disp,
    input  logic               mem_access,
    input  logic               real_mode,
    output logic [SEL_W-1:0]   rd_sel_a,
    output logic [SEL_W-1:0]   rd_sel_b,
    input  logic [W-1:0]       rd_data_a,
    input  logic [W-1:0]       rd_data_b,
    output logic               out_valid,
    output logic [W-1:0]       addr,
    output logic               err,
    output logic               fault
);
    agu_out_t     state_d, state_q;
    logic [W-1:0] idx_term;
    logic [W-1:0] sum;
    logic         rule_bad;

    assign rd_sel_a = base_sel;
    assign rd_sel_b = idx_sel;

    agu_scaler #(.W(W), .SCALE_W(SCALE_W)) u_scaler (
        .en     (idx_en),
        .val    (rd_data_b),
        .scale  (scale),
        .scaled (idx_term)
    );

    agu_sp_rule #(.SEL_W(SEL_W), .SCALE_W(SCALE_W), .SP_SEL(AGU_SP_SEL)) u_rule (
        .base_en  (base_en),
        .base_sel (base_sel),
        .idx_en   (idx_en),
        .idx_sel  (idx_sel),
        .scale    (scale),
        .bad      (rule_bad)
    );

    agu_sum3 #(.W(W)) u_sum (
        .base_en  (base_en),
        .base_val (rd_data_a),
        .idx_term (idx_term),
        .disp     (disp),
        .sum      (sum)
    );

    always_comb begin
        state_d       = state_q;
        state_d.valid = in_valid;
        if (in_valid) begin
            state_d.err   = rule_bad;
            state_d.addr  = rule_bad ? '0 : sum;
            state_d.fault = !rule_bad && mem_access && real_mode && (sum > OFFSET_MAX);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign out_valid = state_q.valid;
    assign addr      = state_q.addr;
    assign err       = state_q.err;
    assign fault     = state_q.fault;
endmodule

// File: rtl/sidx_agu_checker.sv
module sidx_agu_checker
    import agu_pkg::*;
#(
    parameter int W       = AGU_DATA_W,
    parameter int SEL_W   = AGU_SEL_W,
    parameter int SCALE_W = AGU_SCL_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               base_en,
    input logic [SEL_W-1:0]   base_sel,
    input logic               idx_en,
    input logic [SEL_W-1:0]   idx_sel,
    input logic [SCALE_W-1:0] scale,
    input logic               mem_access,
    input logic               real_mode,
    input logic               out_valid,
    input logic [W-1:0]       addr,
    input logic               err,
    input logic               fault
);
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r1_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(addr) && $stable(err) && $stable(fault)));

    a_r5_scaled_sp: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && idx_en && idx_sel == AGU_SP_SEL && scale != '0) |=> (err && !fault && addr == '0));

    a_r6_double_sp: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && idx_en && idx_sel == AGU_SP_SEL && base_en && base_sel == AGU_SP_SEL) |=> err);

    a_r7_single_sp_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !(idx_en && idx_sel == AGU_SP_SEL)) |=> !err);

    a_r8_fault_range: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (addr > 32'h0000_FFFF && !err));

    a_r9_addr_only: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (!mem_access || !real_mode)) |=> !fault);
endmodule

bind sidx_agu sidx_agu_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .base_en    (base_en),
    .base_sel   (base_sel),
    .idx_en     (idx_en),
    .idx_sel    (idx_sel),
    .scale      (scale),
    .mem_access (mem_access),
    .real_mode  (real_mode),
    .out_valid  (out_valid),
    .addr       (addr),
    .err        (err),
    .fault      (fault)
);

// File: tb/sidx_agu_bench.sv
`timescale 1ns/1ps
module sidx_agu_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        base_en = 1'b0;
    logic [2:0]  base_sel = '0;
    logic        idx_en = 1'b0;
    logic [2:0]  idx_sel = '0;
    logic [1:0]  scale = '0;
    logic [31:0] disp = '0;
    logic        mem_access = 1'b0;
    logic        real_mode = 1'b0;
    logic [2:0]  rd_sel_a, rd_sel_b;
    logic [31:0] rd_data_a, rd_data_b;
    logic        out_valid;
    logic [31:0] addr;
    logic        err, fault;

    int checks = 0;
    int fails  = 0;
    logic [31:0] regs [8];
    logic [31:0] disps [4];

    always #4 clk = ~clk;

    assign rd_data_a = regs[rd_sel_a];
    assign rd_data_b = regs[rd_sel_b];

    sidx_agu u_sidx_agu (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .base_en(base_en), .base_sel(base_sel), .idx_en(idx_en), .idx_sel(idx_sel),
        .scale(scale), .disp(disp), .mem_access(mem_access), .real_mode(real_mode),
        .rd_sel_a(rd_sel_a), .rd_sel_b(rd_sel_b), .rd_data_a(rd_data_a), .rd_data_b(rd_data_b),
        .out_valid(out_valid), .addr(addr), .err(err), .fault(fault)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one request; output registered at the next edge, sampled at the negedge after
    task automatic run(input logic be, input logic [2:0] bs, input logic ie, input logic [2:0] is,
                       input logic [1:0] sc, input logic [31:0] d, input logic ma, input logic rm,
                       input bit hold_chk);
        logic        e_err, e_fault;
        logic [31:0] e_addr, mult;
        string       at, et, ft;
        @(negedge clk);
        in_valid = 1'b1; base_en = be; base_sel = bs; idx_en = ie; idx_sel = is;
        scale = sc; disp = d; mem_access = ma; real_mode = rm;
        #1;
        chk("R10 rd_sel_a", {29'd0, rd_sel_a}, {29'd0, bs});
        chk("R10 rd_sel_b", {29'd0, rd_sel_b}, {29'd0, is});
        // expected from requirements; register 4 is the stack pointer
        e_err  = ie && (is == 3'd4) && ((sc != 2'd0) || (be && bs == 3'd4));
        mult   = 32'd1 << sc;
        e_addr = (be ? regs[bs] : 32'd0) + (ie ? regs[is] * mult : 32'd0) + d;
        if (e_err) e_addr = 32'd0;
        e_fault = !e_err && ma && rm && (e_addr > 32'h0000_FFFF);
        if (!be || !ie)     at = "R3 addr";
        else if (bs == is)  at = "R4 addr";
        else                at = "R2 addr";
        if (ie && is == 3'd4 && sc != 2'd0)      et = "R5 err";
        else if (ie && is == 3'd4 && be && bs == 3'd4) et = "R6 err";
        else                                     et = "R7 err";
        ft = (ma && rm) ? "R8 fault" : "R9 fault";
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1 out_valid", {31'd0, out_valid}, 32'd1);
        chk(at, addr, e_addr);
        chk(et, {31'd0, err}, {31'd0, e_err});
        chk(ft, {31'd0, fault}, {31'd0, e_fault});
        if (hold_chk) begin
            disp = ~d; base_sel = ~bs;
            @(negedge clk);
            chk("R1 idle valid", {31'd0, out_valid}, 32'd0);
            chk("R1 hold addr", addr, e_addr);
            chk("R1 hold err", {31'd0, err}, {31'd0, e_err});
            chk("R1 hold fault", {31'd0, fault}, {31'd0, e_fault});
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) regs[i] = 32'h0000_2001 * i + 32'd3;
        regs[7] = 32'hFFFF_8005;
        disps[0] = 32'd0; disps[1] = 32'h0000_0010;
        disps[2] = 32'hFFFF_FFC0; disps[3] = 32'h0001_0000;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset valid", {31'd0, out_valid}, 32'd0);
        chk("R1 reset addr", addr, 32'd0);
        chk("R1 reset flags", {30'd0, err, fault}, 32'd0);
        rst_n = 1'b1;
        // R2 R3 R4 R5 R6 R7 R8 R9 R10: full sweep of selects, enables, scales, modes
        for (int m = 0; m < 4; m++)
            for (int en = 0; en < 4; en++)
                for (int b = 0; b < 8; b++)
                    for (int x = 0; x < 8; x++)
                        for (int s = 0; s < 4; s++)
                            run(en[0], b[2:0], en[1], x[2:0], s[1:0], disps[(b + x + s) % 4],
                                m[0], m[1], (b == x) && (s == 1));
        // R8 boundary: exactly 0xFFFF versus 0x10000 on a real-mode access
        run(1'b0, 3'd0, 1'b0, 3'd0, 2'd0, 32'h0000_FFFF, 1'b1, 1'b1, 1'b1);
        chk("R8 at limit", {31'd0, fault}, 32'd0);
        run(1'b0, 3'd0, 1'b0, 3'd0, 2'd0, 32'h0001_0000, 1'b1, 1'b1, 1'b1);
        chk("R8 above limit", {31'd0, fault}, 32'd1);
        // R2 wrap: large base plus large displacement
        run(1'b1, 3'd7, 1'b0, 3'd0, 2'd0, 32'h0000_8000, 1'b0, 1'b0, 1'b0);
        chk("R2 wrap", addr, 32'h0000_0005);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule